// File: doc/BRIEF.md
# Interrupt Redirection Unit

This block sits inside a PCI host bridge and turns eight level-sensitive interrupt lines into posted message writes. Each line owns two words of a 32-entry redirection table: a control word (vector, mask and mode flags) and a destination word. The destination is kept in a packed, field-swapped form. Software does not reach the table directly. It writes an entry index to a select register and then reads or writes that entry through a window register.

When an enabled line with a valid destination is high, the unit sets one bit of an interrupt latch. The bit is picked by the low bits of the line's vector. The message goes out only on the clear-to-set change of that bit, so a line held high produces one message. An end-of-interrupt write names a vector. It clears the latch bit of every line whose vector matches. If such a line is still active, the bit is set again and a fresh message follows.

Messages leave through a single-entry valid/ready port. Lines that are waiting are served lowest index first.

Top module: `intr_redir_unit`

## Requirements
- R1: After reset the latch reads zero, no message is offered and the select register reads zero. The control word of line i (table index 16+2i) reads 0x1A000 + (i+2), which means masked (bit 16), level (bit 15), active-low (bit 13) and vector i+2. Every destination word (index 17+2i) reads the packed form of CPU_ADDR, {a[19:12], a[27:20], 16'h0}, which is 0xB0FF0000 by default. All other entries read zero.
- R2: A write to offset 0x800 loads the full 32-bit select register, and a read of 0x800 returns it. With select below 32, a write to offset 0x810 stores the whole word into table entry select, and a read of 0x810 returns that entry.
- R3: With select equal to 1, a read of 0x810 returns the version word. This word holds the entry count 32 in bits 31:16 and 1 in bits 15:0, giving 0x00200001.
- R4: With select 32 or above, a window read returns 0xFFFFFFFF and a window write changes no entry.
- R5: A line is active when its input is high, bit 16 of its control word is clear, and bits 31:16 of its destination word are not all zero. An active line sets latch bit (vector & 7) at the next clock edge. The vector is bits 5:0 of the control word.
- R6: A message is created only when a latch bit goes from clear to set. Its data is the 6-bit vector, zero-extended. Its 64-bit address has all ones in bits 63:32 and {4'hF, d[23:16], d[31:24], 12'h0} in bits 31:0, where d is the destination word.
- R7: If a latch bit is mapped only by inactive lines (input low, masked, or zero destination field), it is cleared at the next edge and no message is created.
- R8: A write to offset 0x840 uses only bits 5:0 as a vector. It clears the latch bit of every line whose vector equals that value. A matching line that is still active re-sets the bit in the same edge and sends a new message. A vector that matches no line has no effect.
- R9: At most one message is offered at a time. While msg_valid is high and msg_ready is low, the address and data hold steady.
- R10: Lines waiting to send are served in ascending line order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_in | input | 8 | Level-sensitive interrupt lines |
| latched_irqs | output | 8 | Interrupt latch contents |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 64 | Message destination address |
| msg_data | output | 32 | Message payload (vector) |

## Verification
Suppose the latch holds a wrong value. A stuck set bit shows up as a message that never comes back after an end-of-interrupt. A stuck clear bit shows up as a repeated message on a line held high. Both are visible within three clock edges of the stimulus. A corrupted table entry changes the window read at once, and it changes the next message's address or vector. The bench uses a fresh vector and a fresh destination for every line, so a wrong bit selection or a wrong field swap changes the message seen in that same test. A fault in the pending set shows up as reordered or duplicated messages in the eight-line burst.

// File: rtl/intr_redir_pkg.sv
package intr_redir_pkg;
  localparam int unsigned VEC_W       = 6;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned MASK_BIT    = 16;
  localparam int unsigned LEVEL_BIT   = 15;
  localparam int unsigned POL_LO_BIT  = 13;
  localparam int unsigned LOWPRI_BIT  = 8;
  localparam int unsigned RST_VEC_OFS = 2;
  localparam logic [31:0] SEL_OFS     = 32'h800;
  localparam logic [31:0] WIN_OFS     = 32'h810;
  localparam logic [31:0] EOI_OFS     = 32'h840;
  localparam logic [31:0] CFG_RST_FLAGS =
    (32'd1 << MASK_BIT) | (32'd1 << LEVEL_BIT) | (32'd1 << POL_LO_BIT);

  // packed destination form: id byte on top, eid byte below it
  function automatic logic [31:0] swizzle_dest(input logic [31:0] a);
    return {a[19:12], a[27:20], 16'h0000};
  endfunction

  function automatic logic [31:0] unswizzle_dest(input logic [31:0] d);
    return {4'hf, d[23:16], d[31:24], 12'h000};
  endfunction
endpackage

// File: rtl/intr_redir_regs.sv
module intr_redir_regs
  import intr_redir_pkg::*;
#(
  parameter int unsigned N_LINES   = 8,
  parameter int unsigned TBL_DEPTH = 32,
  parameter int unsigned BASE_IDX  = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [31:0] CPU_ADDR  = 32'hfffb0000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_wr,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [WORD_W-1:0]               reg_wdata,
  output logic [WORD_W-1:0]               reg_rdata,
  output logic                            eoi_valid,
  output logic [VEC_W-1:0]                eoi_vec,
  output logic [N_LINES-1:0][VEC_W-1:0]   line_vec,
  output logic [N_LINES-1:0]              line_masked,
  output logic [N_LINES-1:0]              line_routed,
  output logic [N_LINES-1:0][WORD_W-1:0]  line_route
);
  localparam int unsigned IDX_W = $clog2(TBL_DEPTH);
  localparam logic [WORD_W-1:0] VERSION = {16'(TBL_DEPTH), 16'd1};

  function automatic logic [31:0] entry_reset(input int idx);
    int rel;
    rel = idx - int'(BASE_IDX);
    if (rel < 0 || rel >= int'(2 * N_LINES)) return '0;
    if (rel % 2 == 0) return CFG_RST_FLAGS | 32'(rel / 2 + int'(RST_VEC_OFS));
    return swizzle_dest(CPU_ADDR);
  endfunction

  logic [WORD_W-1:0] sel_q;
  logic [WORD_W-1:0] sel_d;
  logic              sel_en;
  logic              hit_sel, hit_win, hit_eoi;
  logic              sel_ok;
  logic [IDX_W-1:0]  sel_idx;
  logic [WORD_W-1:0] tbl [TBL_DEPTH];

  always_comb begin
    hit_sel = (reg_addr == ADDR_W'(SEL_OFS));
    hit_win = (reg_addr == ADDR_W'(WIN_OFS));
    hit_eoi = (reg_addr == ADDR_W'(EOI_OFS));
    sel_ok  = (sel_q < 32'(TBL_DEPTH));
    sel_idx = sel_q[IDX_W-1:0];
    sel_en  = reg_wr && hit_sel;
    sel_d   = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  for (genvar e = 0; e < int'(TBL_DEPTH); e++) begin : g_ent
    localparam logic [31:0] RST_VAL = entry_reset(e);
    logic [WORD_W-1:0] ent_q;
    logic              ent_en;
    assign ent_en = reg_wr && hit_win && sel_ok && (sel_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= RST_VAL;
      else if (ent_en) ent_q <= reg_wdata;
    end
    assign tbl[e] = ent_q;
  end

  for (genvar l = 0; l < int'(N_LINES); l++) begin : g_line
    assign line_vec[l]    = tbl[BASE_IDX + 2*l][VEC_W-1:0];
    assign line_masked[l] = tbl[BASE_IDX + 2*l][MASK_BIT];
    assign line_routed[l] = |tbl[BASE_IDX + 2*l + 1][31:16];
    assign line_route[l]  = unswizzle_dest(tbl[BASE_IDX + 2*l + 1]);
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_sel) begin
      reg_rdata = sel_q;
    end else if (hit_win) begin
      if (sel_q == 32'd1) reg_rdata = VERSION;
      else if (sel_ok)    reg_rdata = tbl[sel_idx];
      else                reg_rdata = '1;
    end
  end

  assign eoi_valid = reg_wr && hit_eoi;
  assign eoi_vec   = reg_wdata[VEC_W-1:0];
endmodule

// File: rtl/intr_redir_latch.sv
module intr_redir_latch
  import intr_redir_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_LINES-1:0]            irq_in,
  input  logic [N_LINES-1:0][VEC_W-1:0] line_vec,
  input  logic [N_LINES-1:0]            line_masked,
  input  logic [N_LINES-1:0]            line_routed,
  input  logic                          eoi_valid,
  input  logic [VEC_W-1:0]              eoi_vec,
  output logic [N_LINES-1:0]            latched,
  output logic [N_LINES-1:0]            raise
);
  localparam int unsigned BIT_W = $clog2(N_LINES);

  logic [N_LINES-1:0]            latch_q, latch_d;
  logic [N_LINES-1:0]            act;
  logic [N_LINES-1:0][BIT_W-1:0] bidx;
  logic [N_LINES-1:0]            eoi_clr, set_hit, clr_hit, base, fresh, claimed;

  always_comb begin
    eoi_clr = '0;
    set_hit = '0;
    clr_hit = '0;
    for (int i = 0; i < int'(N_LINES); i++) begin
      bidx[i] = line_vec[i][BIT_W-1:0];
      act[i]  = irq_in[i] && !line_masked[i] && line_routed[i];
      if (eoi_valid && (line_vec[i] == eoi_vec)) eoi_clr[bidx[i]] = 1'b1;
      if (act[i]) set_hit[bidx[i]] = 1'b1;
      else        clr_hit[bidx[i]] = 1'b1;
    end
    base    = latch_q & ~eoi_clr;
    latch_d = (base & ~clr_hit) | set_hit;
    fresh   = set_hit & ~base;
    claimed = '0;
    raise   = '0;
    for (int i = 0; i < int'(N_LINES); i++) begin
      if (act[i] && fresh[bidx[i]] && !claimed[bidx[i]]) begin
        raise[i]          = 1'b1;
        claimed[bidx[i]]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  assign latched = latch_q;
endmodule

// File: rtl/intr_redir_msg.sv
module intr_redir_msg
  import intr_redir_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_LINES-1:0]             raise,
  input  logic [N_LINES-1:0][VEC_W-1:0]  line_vec,
  input  logic [N_LINES-1:0][WORD_W-1:0] line_route,
  output logic                           msg_valid,
  input  logic                           msg_ready,
  output logic [63:0]                    msg_addr,
  output logic [WORD_W-1:0]              msg_data
);
  localparam int unsigned IDX_W = $clog2(N_LINES);

  logic [N_LINES-1:0] pend_q, pend_d, take;
  logic               valid_q, valid_d;
  logic               slot_free, found, load;
  logic [IDX_W-1:0]   pick;
  logic [63:0]        addr_q;
  logic [WORD_W-1:0]  data_q;

  always_comb begin
    take  = '0;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < int'(N_LINES); i++) begin
      if (pend_q[i] && !found) begin
        found   = 1'b1;
        take[i] = 1'b1;
        pick    = IDX_W'(i);
      end
    end
    slot_free = !valid_q || msg_ready;
    load      = slot_free && found;
    if (!load) take = '0;
    pend_d  = (pend_q & ~take) | raise;
    valid_d = slot_free ? found : valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      addr_q <= {32'hffff_ffff, line_route[pick]};
      data_q <= WORD_W'(line_vec[pick]);
    end
  end

  assign msg_valid = valid_q;
  assign msg_addr  = addr_q;
  assign msg_data  = data_q;
endmodule

// File: rtl/intr_redir_unit.sv
module intr_redir_unit
  import intr_redir_pkg::*;
#(
  parameter int unsigned N_LINES   = 8,
  parameter int unsigned TBL_DEPTH = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [31:0] CPU_ADDR  = 32'hfffb0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [N_LINES-1:0] irq_in,
  output logic [N_LINES-1:0] latched_irqs,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam int unsigned BASE_IDX = TBL_DEPTH / 2;

  logic                           eoi_valid;
  logic [VEC_W-1:0]               eoi_vec;
  logic [N_LINES-1:0][VEC_W-1:0]  line_vec;
  logic [N_LINES-1:0]             line_masked;
  logic [N_LINES-1:0]             line_routed;
  logic [N_LINES-1:0][WORD_W-1:0] line_route;
  logic [N_LINES-1:0]             raise;

  intr_redir_regs #(
    .N_LINES(N_LINES), .TBL_DEPTH(TBL_DEPTH), .BASE_IDX(BASE_IDX),
    .ADDR_W(ADDR_W), .CPU_ADDR(CPU_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
    .line_vec(line_vec), .line_masked(line_masked),
    .line_routed(line_routed), .line_route(line_route)
  );

  intr_redir_latch #(.N_LINES(N_LINES)) u_latch (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .line_vec(line_vec), .line_masked(line_masked), .line_routed(line_routed),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
    .latched(latched_irqs), .raise(raise)
  );

  intr_redir_msg #(.N_LINES(N_LINES)) u_msg (
    .clk(clk), .rst_n(rst_n), .raise(raise),
    .line_vec(line_vec), .line_route(line_route),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: rtl/intr_redir_chk.sv
module intr_redir_chk
  import intr_redir_pkg::*;
#(
  parameter int unsigned N_LINES   = 8,
  parameter int unsigned TBL_DEPTH = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           reg_wr,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic [31:0]                    reg_wdata,
  input logic [N_LINES-1:0]             irq_in,
  input logic [N_LINES-1:0]             latched_irqs,
  input logic                           msg_valid,
  input logic                           msg_ready,
  input logic [63:0]                    msg_addr,
  input logic [31:0]                    msg_data,
  input logic [31:0]                    sel_q,
  input logic [N_LINES-1:0][VEC_W-1:0]  line_vec,
  input logic [N_LINES-1:0]             line_masked,
  input logic [N_LINES-1:0][WORD_W-1:0] line_route
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (latched_irqs == '0 && !msg_valid);
    end
  end

  // R2
  sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(SEL_OFS)) |=> (sel_q == $past(reg_wdata)));

  // R4
  oob_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(WIN_OFS) && sel_q >= 32'(TBL_DEPTH))
    |=> ($stable(line_vec) && $stable(line_masked) && $stable(line_route)));

  // R5
  quiet_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_irqs == '0 && irq_in == '0) |=> (latched_irqs == '0));

  // R9
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
endmodule

bind intr_redir_unit intr_redir_chk #(
  .N_LINES(N_LINES), .TBL_DEPTH(TBL_DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_in(irq_in), .latched_irqs(latched_irqs),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
  .msg_data(msg_data), .sel_q(u_regs.sel_q), .line_vec(line_vec),
  .line_masked(line_masked), .line_route(line_route)
);

// File: tb/intr_redir_unit_bench.sv
module intr_redir_unit_bench;
  localparam logic [11:0] A_SEL = 12'h800;
  localparam logic [11:0] A_WIN = 12'h810;
  localparam logic [11:0] A_EOI = 12'h840;
  localparam logic [31:0] CPU_A = 32'hfffb0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_in;
  logic [7:0]  latched_irqs;
  logic        msg_valid;
  logic        msg_ready;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  intr_redir_unit u_intr_redir_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .latched_irqs(latched_irqs), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] tbl_m [32];
  logic [63:0] rx_addr [64];
  logic [31:0] rx_data [64];
  int rx_n = 0;

  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready && rx_n < 64) begin
      rx_addr[rx_n] = msg_addr;
      rx_data[rx_n] = msg_data;
      rx_n = rx_n + 1;
    end
  end

  function automatic logic [31:0] swz(input logic [31:0] a);
    return ((a & 32'h0ff00000) >> 4) | ((a & 32'h000ff000) << 12);
  endfunction
  function automatic logic [63:0] exp_addr(input logic [31:0] d);
    return {32'hffffffff,
            ((d << 4) & 32'h0ff00000) | ((d >> 12) & 32'h000ff000) | 32'hf0000000};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic win_wr(input logic [31:0] idx, input logic [31:0] d);
    wr(A_SEL, idx);
    wr(A_WIN, d);
    if (idx < 32) tbl_m[idx[4:0]] = d;
  endtask

  task automatic win_chk(input string tag, input logic [31:0] idx, input logic [31:0] exp);
    wr(A_SEL, idx);
    rd_chk(tag, A_WIN, exp);
  endtask

  task automatic waitn(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    irq_in = '0; msg_ready = 1'b1;
    for (int e = 0; e < 32; e++) tbl_m[e] = '0;
    for (int i = 0; i < 8; i++) begin
      tbl_m[16 + 2*i]     = 32'h1A000 + 32'(i + 2);
      tbl_m[16 + 2*i + 1] = swz(CPU_A);
    end
    waitn(3);
    chk("R1 latch in reset", 64'(latched_irqs), 64'h0);
    chk("R1 no msg in reset", 64'(msg_valid), 64'h0);
    rst_n = 1'b1;
    waitn(1);
    rd_chk("R1 select reset", A_SEL, 32'h0);
    chk("R1 packed cpu addr", 64'(swz(CPU_A)), 64'hb0ff0000);
    for (int e = 0; e < 32; e++)
      if (e != 1) win_chk($sformatf("R1 entry %0d reset", e), e, tbl_m[e]);

    win_chk("R3 version word", 1, 32'h00200001);

    // R2 sweep: pattern in every entry, read back, restore
    for (int e = 0; e < 32; e++) if (e != 1) win_wr(e, 32'h5a000000 ^ (32'(e) * 32'h01030507) | 32'h10000);
    for (int e = 0; e < 32; e++) if (e != 1) win_chk($sformatf("R2 entry %0d", e), e, tbl_m[e]);
    wr(A_SEL, 32'h12345678);
    rd_chk("R2 select readback", A_SEL, 32'h12345678);

    // R4 out of range
    rd_chk("R4 oob read", A_WIN, 32'hffffffff);
    wr(A_SEL, 32);
    rd_chk("R4 oob read 32", A_WIN, 32'hffffffff);
    wr(A_WIN, 32'h0);
    wr(A_SEL, 40);
    wr(A_WIN, 32'h0);
    for (int e = 0; e < 32; e++) if (e != 1) win_chk($sformatf("R4 entry %0d kept", e), e, tbl_m[e]);

    // restore masked defaults on all lines
    for (int i = 0; i < 8; i++) begin
      win_wr(16 + 2*i, 32'h1A000 + 32'(i + 2));
      win_wr(16 + 2*i + 1, swz(CPU_A));
    end

    // R5/R6/R7 per line sweep
    for (int i = 0; i < 8; i++) begin
      logic [5:0]  v;
      logic [31:0] d;
      v = 6'((i * 9 + 5) & 63);
      d = {8'(8'h10 + i), 8'(8'h40 + 3*i), 16'h0};
      win_wr(16 + 2*i, 32'(v));
      win_wr(16 + 2*i + 1, d);
      rx_n = 0;
      @(negedge clk); irq_in[i] = 1'b1;
      @(negedge clk);
      chk($sformatf("R5 line %0d latch", i), 64'(latched_irqs), 64'(8'd1 << v[2:0]));
      waitn(4);
      chk($sformatf("R6 line %0d count", i), 64'(rx_n), 64'd1);
      chk($sformatf("R6 line %0d data", i), 64'(rx_data[0]), 64'(v));
      chk($sformatf("R6 line %0d addr", i), rx_addr[0], exp_addr(d));
      irq_in[i] = 1'b0;
      @(negedge clk);
      chk($sformatf("R7 line %0d deassert", i), 64'(latched_irqs), 64'h0);
      win_wr(16 + 2*i, 32'h10000 | 32'(v));
    end

    // R7 masked line and zero destination
    rx_n = 0;
    win_wr(20, 32'h10000 | 32'h13);
    @(negedge clk); irq_in[2] = 1'b1;
    waitn(4);
    chk("R7 masked latch", 64'(latched_irqs), 64'h0);
    chk("R7 masked no msg", 64'(rx_n), 64'd0);
    irq_in[2] = 1'b0;
    win_wr(22, 32'h13);
    win_wr(23, 32'h0000ffff);
    @(negedge clk); irq_in[3] = 1'b1;
    waitn(4);
    chk("R7 zero dest latch", 64'(latched_irqs), 64'h0);
    chk("R7 zero dest no msg", 64'(rx_n), 64'd0);
    irq_in[3] = 1'b0;
    win_wr(22, 32'h10013);

    // R8 end of interrupt
    win_wr(24, 32'h2c);
    win_wr(25, 32'h77550000);
    rx_n = 0;
    @(negedge clk); irq_in[4] = 1'b1;
    waitn(4);
    chk("R8 first msg", 64'(rx_n), 64'd1);
    wr(A_EOI, 32'h2d);
    waitn(4);
    chk("R8 nonmatching eoi", 64'(rx_n), 64'd1);
    wr(A_EOI, 32'hffffffec);
    waitn(4);
    chk("R8 matching eoi remsg", 64'(rx_n), 64'd2);
    chk("R8 remsg data", 64'(rx_data[1]), 64'h2c);
    chk("R8 latch kept", 64'(latched_irqs), 64'h10);
    irq_in[4] = 1'b0;
    waitn(2);

    // R9/R10 burst on all lines with receiver stalled
    for (int i = 0; i < 8; i++) begin
      win_wr(16 + 2*i, 32'(i | ((7 - i) << 3)));
      win_wr(16 + 2*i + 1, {8'(8'h21 + i), 8'(8'h90 + i), 16'h0});
    end
    rx_n = 0;
    @(negedge clk); msg_ready = 1'b0; irq_in = 8'hff;
    waitn(3);
    chk("R10 first offered", 64'(msg_data), 64'h38);
    chk("R9 valid held", 64'(msg_valid), 64'h1);
    waitn(5);
    chk("R9 data stable", 64'(msg_data), 64'h38);
    chk("R9 addr stable", msg_addr, exp_addr({8'h21, 8'h90, 16'h0}));
    chk("R9 none accepted", 64'(rx_n), 64'd0);
    msg_ready = 1'b1;
    waitn(12);
    chk("R10 count", 64'(rx_n), 64'd8);
    for (int k = 0; k < 8; k++) begin
      chk($sformatf("R10 order data %0d", k), 64'(rx_data[k]), 64'(k | ((7 - k) << 3)));
      chk($sformatf("R10 order addr %0d", k), rx_addr[k],
          exp_addr({8'(8'h21 + k), 8'(8'h90 + k), 16'h0}));
    end
    chk("R5 all latched", 64'(latched_irqs), 64'hff);
    irq_in = '0;
    waitn(2);
    chk("R7 all cleared", 64'(latched_irqs), 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule